// File: doc/BRIEF.md
# PCIe Receive Header/Payload Realigner

This block sits on the receive side of a PCI Express transaction layer with a 128-bit datapath. Packets arrive as beats of four dwords, marked with start-of-packet, end-of-packet and an empty flag for the final beat. The block splits each packet into two output channels. The header channel carries one beat per packet with the three- or four-dword header. The payload channel carries the data dwords packed densely, so that the first payload dword of every packet is always in lane 0.

Where the first payload dword sits on the input depends on the header size and on bit 2 of the address. The block works out that offset, drops any padding dword, and joins dwords from consecutive input beats into full output beats. The input follows a ready-latency rule: the source may still deliver up to three beats after the block lowers `in_ready`. A small internal queue holds those beats. The queue lowers `in_ready` early enough that none of them is lost.

Top module: `tlp_rx_realign`

## Requirements
- R1: While reset is held, `hdr_valid` and `pl_valid` are low and `in_ready` is high.
- R2: Each start-of-packet beat produces exactly one header beat. `hdr_four` equals bit 29 of dword 0, the dword in bits [31:0]. Dwords 0 to 2 are passed unchanged. Dword 3 is passed for a four-dword header and zeroed for a three-dword header.
- R3: For a three-dword header, the address bit 2 is bit 2 of dword 2. When it is set, the first payload dword is taken from bits [127:96] of the start beat and delivered in lane 0.
- R4: For a three-dword header with address bit 2 clear, bits [127:96] of the start beat are discarded. The payload begins with lane 0 of the next beat.
- R5: For a four-dword header, the payload begins in the beat after the start beat. There, the address bit 2 is bit 2 of dword 3. When it is set, lane 0 of that next beat is a pad and is discarded.
- R6: Payload dwords appear in order and without gaps. Every payload beat except the last has `pl_dwen` = 4'b1111. The final beat carries `pl_last` = 1 and enables the remaining count of dwords from lane 0 upward. That count comes from the length field in bits [9:0] of dword 0, where 0 means 1024. Disabled lanes are zero.
- R7: When bit 30 of dword 0 is clear (no payload), no payload beat is produced for that packet.
- R8: `in_ready` is low whenever fewer than four queue entries are free. Every beat presented with `in_valid` within three cycles after `in_ready` falls is stored and delivered.
- R9: Back-to-back packets, with start on the beat right after the previous end, and single-beat packets, with start and end together, are handled with no loss and no merging.
- R10: A valid header or payload beat that is not accepted stays valid with unchanged contents in the next cycle.
- R11: Output beats on each channel appear in the order of their packets, and nothing is emitted beyond what the input packets define.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Queue has room for the ready-latency window |
| in_data | input | 128 | Input beat, dword n in bits [32n+31:32n] |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_empty | input | 1 | On the last beat, only the low 64 bits are valid |
| hdr_valid | output | 1 | Header beat available |
| hdr_ready | input | 1 | Header consumer accepts |
| hdr_data | output | 128 | Header dwords, dword 3 zero for a three-dword header |
| hdr_four | output | 1 | Header is four dwords |
| pl_valid | output | 1 | Payload beat available |
| pl_ready | input | 1 | Payload consumer accepts |
| pl_data | output | 128 | Realigned payload dwords |
| pl_dwen | output | 4 | Per-lane dword enable, contiguous from lane 0 |
| pl_last | output | 1 | Final payload beat of the packet |

## Verification
A wrong lane offset or a stale pad flag appears on the very first payload beat of the affected packet, as a dword from the header or a pad dword in lane 0. A miscounted carry register shifts every following dword of the packet by one lane and corrupts its final `pl_dwen`. A carry left over from one packet leaks into lane 0 of the next packet's first beat. The sweep covers every header-size and alignment combination with lengths from one to nine dwords. That exposes every carry count from 0 to 3 and every final-beat fill. A queue that lowers `in_ready` too late loses or overwrites a beat, which shows as a missing or wrong dword within a few cycles of a stall on the payload output.

// File: rtl/tlp_rx_pkg.sv
package tlp_rx_pkg;
    localparam int DW_BITS   = 32;
    localparam int LANES     = 4;
    localparam int BEAT_BITS = DW_BITS * LANES;
    localparam int LEN_BITS  = 10;
    localparam int CNT_BITS  = LEN_BITS + 1;
    localparam int FMT4_BIT  = 29;
    localparam int HASD_BIT  = 30;
    localparam int ADDR2_BIT = 2;
    localparam int CARRY_MAX = LANES - 1;

    typedef logic [DW_BITS-1:0] dword_t;

    typedef struct packed {
        logic [BEAT_BITS-1:0] data;
        logic                 sop;
        logic                 eop;
        logic                 empty;
    } beat_t;
endpackage

// File: rtl/tlp_rx_skid_fifo.sv
module tlp_rx_skid_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    parameter int SLACK = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         not_empty,
    output logic         full,
    output logic         room_ok
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic [W-1:0] mem [DEPTH];
    logic wr, rd;

    always_comb begin
        d  = q;
        wr = wr_en && (int'(q.cnt) != DEPTH);
        rd = rd_en && (q.cnt != '0);
        if (wr) d.wp = (int'(q.wp) == DEPTH - 1) ? '0 : q.wp + 1'b1;
        if (rd) d.rp = (int'(q.rp) == DEPTH - 1) ? '0 : q.rp + 1'b1;
        case ({wr, rd})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (wr) mem[q.wp] <= wr_data;
    end

    assign rd_data   = mem[q.rp];
    assign not_empty = (q.cnt != '0);
    assign full      = (int'(q.cnt) == DEPTH);
    assign room_ok   = (int'(q.cnt) <= DEPTH - SLACK);
endmodule

// File: rtl/tlp_rx_realign_core.sv
module tlp_rx_realign_core
    import tlp_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  beat_t                beat,
    input  logic                 beat_avail,
    output logic                 pop,
    output logic                 hdr_valid,
    input  logic                 hdr_ready,
    output logic [BEAT_BITS-1:0] hdr_data,
    output logic                 hdr_four,
    output logic                 pl_valid,
    input  logic                 pl_ready,
    output logic [BEAT_BITS-1:0] pl_data,
    output logic [LANES-1:0]     pl_dwen,
    output logic                 pl_last
);
    localparam int SPAN = LANES + CARRY_MAX;

    typedef struct packed {
        logic                             hv;
        logic [BEAT_BITS-1:0]             hdata;
        logic                             hfour;
        logic                             pv;
        logic [BEAT_BITS-1:0]             pdata;
        logic [LANES-1:0]                 pdwen;
        logic                             plast;
        logic [CARRY_MAX-1:0][DW_BITS-1:0] carry;
        logic [1:0]                       ccnt;
        logic                             flush;
        logic                             skip;
        logic [CNT_BITS-1:0]              rem;
    } core_st_t;

    core_st_t q, d;

    function automatic dword_t lane_of(input logic [BEAT_BITS-1:0] data, input int j);
        dword_t r;
        r = '0;
        for (int i = 0; i < LANES; i++)
            if (i == j) r = data[i*DW_BITS +: DW_BITS];
        return r;
    endfunction

    always_comb begin
        logic                fmt4, hasd, a2, hfree, pfree, emit, go, last_n, flush_n;
        logic [CNT_BITS-1:0] len;
        int                  s, n, k, t, cc, avail_k, rem_in, ecnt, newc;
        dword_t              cmb [SPAN];
        logic [BEAT_BITS-1:0] odata, fdata;
        logic [LANES-1:0]    odwen, fdwen;

        d   = q;
        pop = 1'b0;
        if (q.hv && hdr_ready) d.hv = 1'b0;
        if (q.pv && pl_ready)  d.pv = 1'b0;
        hfree = !q.hv || hdr_ready;
        pfree = !q.pv || pl_ready;

        // header fields of a start beat
        fmt4 = beat.data[FMT4_BIT];
        hasd = beat.data[HASD_BIT];
        len  = (beat.data[LEN_BITS-1:0] == '0) ? CNT_BITS'(1 << LEN_BITS)
                                               : {1'b0, beat.data[LEN_BITS-1:0]};
        a2   = fmt4 ? beat.data[3*DW_BITS + ADDR2_BIT] : beat.data[2*DW_BITS + ADDR2_BIT];

        // first usable lane and remaining payload for this beat
        if (beat.sop) begin
            rem_in = hasd ? int'(len) : 0;
            s      = (!fmt4 && a2) ? 3 : LANES;
        end else begin
            rem_in = int'(q.rem);
            s      = q.skip ? 1 : 0;
        end
        n       = (beat.eop && beat.empty) ? LANES / 2 : LANES;
        avail_k = (n > s) ? n - s : 0;
        k       = (avail_k < rem_in) ? avail_k : rem_in;
        cc      = int'(q.ccnt);
        t       = cc + k;

        // carried dwords followed by this beat's usable dwords
        for (int i = 0; i < CARRY_MAX; i++)
            cmb[i] = (i < cc) ? q.carry[i] : lane_of(beat.data, s + i - cc);
        for (int i = CARRY_MAX; i < SPAN; i++)
            cmb[i] = lane_of(beat.data, s + i - cc);

        ecnt    = 0;
        last_n  = 1'b0;
        flush_n = 1'b0;
        newc    = cc;
        if (beat.eop) begin
            if (t == 0) begin
                newc = 0;
            end else if (t <= LANES) begin
                ecnt = t; last_n = 1'b1; newc = 0;
            end else begin
                ecnt = LANES; newc = t - LANES; flush_n = 1'b1;
            end
        end else if (t >= LANES) begin
            ecnt = LANES; newc = t - LANES;
        end else begin
            newc = t;
        end
        emit = (ecnt > 0);

        for (int i = 0; i < LANES; i++) begin
            odwen[i]                     = (i < ecnt);
            odata[i*DW_BITS +: DW_BITS]  = (i < ecnt) ? cmb[i] : '0;
            fdwen[i]                     = (i < cc);
            fdata[i*DW_BITS +: DW_BITS]  = (i < cc && i < CARRY_MAX) ? cmb[i] : '0;
        end

        go = !q.flush && beat_avail && (!beat.sop || hfree) && (!emit || pfree);

        if (q.flush) begin
            if (pfree) begin
                d.pv    = 1'b1;
                d.pdata = fdata;
                d.pdwen = fdwen;
                d.plast = 1'b1;
                d.ccnt  = '0;
                d.flush = 1'b0;
            end
        end else if (go) begin
            pop = 1'b1;
            if (beat.sop) begin
                d.hv    = 1'b1;
                d.hfour = fmt4;
                d.hdata = fmt4 ? beat.data : {{DW_BITS{1'b0}}, beat.data[3*DW_BITS-1:0]};
                d.skip  = fmt4 && a2;
            end else begin
                d.skip  = 1'b0;
            end
            d.rem = CNT_BITS'(rem_in - k);
            if (emit) begin
                d.pv    = 1'b1;
                d.pdata = odata;
                d.pdwen = odwen;
                d.plast = last_n;
            end
            for (int j = 0; j < CARRY_MAX; j++)
                d.carry[j] = (ecnt == LANES) ? cmb[j + LANES] : cmb[j];
            d.ccnt  = 2'(newc);
            d.flush = flush_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign hdr_valid = q.hv;
    assign hdr_data  = q.hdata;
    assign hdr_four  = q.hfour;
    assign pl_valid  = q.pv;
    assign pl_data   = q.pdata;
    assign pl_dwen   = q.pdwen;
    assign pl_last   = q.plast;
endmodule

// File: rtl/tlp_rx_realign.sv
module tlp_rx_realign
    import tlp_rx_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int READY_LAT = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [BEAT_BITS-1:0] in_data,
    input  logic                 in_sop,
    input  logic                 in_eop,
    input  logic                 in_empty,
    output logic                 hdr_valid,
    input  logic                 hdr_ready,
    output logic [BEAT_BITS-1:0] hdr_data,
    output logic                 hdr_four,
    output logic                 pl_valid,
    input  logic                 pl_ready,
    output logic [BEAT_BITS-1:0] pl_data,
    output logic [LANES-1:0]     pl_dwen,
    output logic                 pl_last
);
    localparam int SLACK  = READY_LAT + 1;
    localparam int BEAT_W = $bits(beat_t);

    beat_t             wr_beat, head;
    logic [BEAT_W-1:0] head_raw;
    logic              head_avail, fifo_full, pop;

    assign wr_beat = '{data: in_data, sop: in_sop, eop: in_eop, empty: in_empty};

    tlp_rx_skid_fifo #(.W(BEAT_W), .DEPTH(DEPTH), .SLACK(SLACK)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (in_valid),
        .wr_data   (wr_beat),
        .rd_en     (pop),
        .rd_data   (head_raw),
        .not_empty (head_avail),
        .full      (fifo_full),
        .room_ok   (in_ready)
    );

    assign head = beat_t'(head_raw);

    tlp_rx_realign_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat       (head),
        .beat_avail (head_avail),
        .pop        (pop),
        .hdr_valid  (hdr_valid),
        .hdr_ready  (hdr_ready),
        .hdr_data   (hdr_data),
        .hdr_four   (hdr_four),
        .pl_valid   (pl_valid),
        .pl_ready   (pl_ready),
        .pl_data    (pl_data),
        .pl_dwen    (pl_dwen),
        .pl_last    (pl_last)
    );
endmodule

// File: rtl/tlp_rx_realign_chk.sv
module tlp_rx_realign_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_ready,
    input logic         fifo_full,
    input logic         hdr_valid,
    input logic         hdr_ready,
    input logic [127:0] hdr_data,
    input logic         hdr_four,
    input logic         pl_valid,
    input logic         pl_ready,
    input logic [127:0] pl_data,
    input logic [3:0]   pl_dwen,
    input logic         pl_last
);
    // R8: no beat may arrive while the queue is full
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> !fifo_full);

    // R8: a full queue never advertises room
    a_r8_ready_low_full: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !in_ready);

    // R10: stalled header beat is held
    a_r10_hdr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !hdr_ready) |=> (hdr_valid && $stable(hdr_data) && $stable(hdr_four)));

    // R10: stalled payload beat is held
    a_r10_pl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_valid && !pl_ready) |=> (pl_valid && $stable(pl_data) && $stable(pl_dwen) && $stable(pl_last)));

    // R6: only the final beat may be partial
    a_r6_full_mid: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_valid && !pl_last) |-> (pl_dwen == 4'b1111));

    // R6: enables are contiguous from lane 0
    a_r6_contig: assert property (@(posedge clk) disable iff (!rst_n)
        pl_valid |-> (pl_dwen == 4'b0001 || pl_dwen == 4'b0011 ||
                      pl_dwen == 4'b0111 || pl_dwen == 4'b1111));

    // R6: a disabled top lane reads zero
    a_r6_zero_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_valid && !pl_dwen[3]) |-> (pl_data[127:96] == 32'h0));

    // R2: a three-dword header carries a zero dword 3
    a_r2_hdr3_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !hdr_four) |-> (hdr_data[127:96] == 32'h0));
endmodule

bind tlp_rx_realign tlp_rx_realign_chk u_chk (.*);

// File: tb/tlp_rx_realign_test.sv
module tlp_rx_realign_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_data = '0;
    logic         in_sop = 1'b0, in_eop = 1'b0, in_empty = 1'b0;
    logic         hdr_valid, hdr_four, pl_valid, pl_last;
    logic         hdr_ready = 1'b0, pl_ready = 1'b0;
    logic [127:0] hdr_data, pl_data;
    logic [3:0]   pl_dwen;

    localparam int LIMIT = 150000;

    int          checks = 0, errors = 0, cyc = 0, mode = 0, pid = 0;
    logic [3:0]  hist = '0;
    logic [15:0] lfsr = 16'hACE1;
    bit          saw_low = 0;

    logic [130:0] src_q [$];
    logic [128:0] exp_h [$];
    logic [132:0] exp_p [$];
    string        tag_p [$];

    always #2.5 clk = ~clk;

    tlp_rx_realign uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_data(hdr_data), .hdr_four(hdr_four),
        .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data), .pl_dwen(pl_dwen),
        .pl_last(pl_last)
    );

    task automatic chk(input bit ok, input string req, input logic [132:0] act, input logic [132:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Build one packet: header, optional pad, payload, padded to whole beats
    task automatic make_pkt(input bit four, input bit hasd, input bit a2, input int len);
        logic [31:0] dq [$];
        logic [31:0] h0, h1, h2, h3, junk;
        logic [127:0] bd, pd;
        int size, nb, np;
        string t0;
        pid++;
        junk = 32'hBAD0_0000 | 32'(pid);
        h0 = {1'b0, hasd, four, 19'(pid), 10'(len)};
        h1 = 32'h5100_0000 | 32'(pid);
        if (four) begin
            h2 = 32'h0000_0001;
            h3 = (32'(pid) << 8) | (a2 ? 32'h4 : 32'h0);
        end else begin
            h2 = (32'(pid) << 8) | (a2 ? 32'h4 : 32'h0);
            h3 = 32'h0;
        end
        dq.push_back(h0); dq.push_back(h1); dq.push_back(h2);
        if (four) dq.push_back(h3);
        if (hasd) begin
            if (four == a2) dq.push_back(junk);   // pad: 3dw aligned or 4dw with bit 2 set
            for (int i = 0; i < len; i++) dq.push_back(32'hA000_0000 | (32'(pid) << 16) | 32'(i));
        end
        size = dq.size();
        nb   = (size + 3) / 4;
        for (int b = 0; b < nb; b++) begin
            for (int i = 0; i < 4; i++)
                bd[i*32 +: 32] = (4*b + i < size) ? dq[4*b + i] : junk;
            src_q.push_back({bd, (b == 0), (b == nb - 1), (b == nb - 1) && (size - 4*b <= 2)});
        end
        exp_h.push_back({four, (four ? h3 : 32'h0), h2, h1, h0});
        if (hasd) begin
            t0 = four ? "R5" : (a2 ? "R3" : "R4");
            np = (len + 3) / 4;
            for (int c = 0; c < np; c++) begin
                int cnt;
                cnt = (len - 4*c < 4) ? len - 4*c : 4;
                for (int i = 0; i < 4; i++)
                    pd[i*32 +: 32] = (i < cnt) ? (32'hA000_0000 | (32'(pid) << 16) | 32'(4*c + i)) : 32'h0;
                exp_p.push_back({pd, 4'((1 << cnt) - 1), (c == np - 1)});
                tag_p.push_back(c == 0 ? t0 : "R6");
            end
        end
    endtask

    // Source, sinks and monitor, all away from the active edge
    always @(negedge clk) begin
        cyc++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (!rst_n) begin
            in_valid  = 1'b0;
            hdr_ready = 1'b0;
            pl_ready  = 1'b0;
            hist      = '0;
        end else begin
            hist = {hist[2:0], in_ready};
            if (!in_ready) saw_low = 1;
            // source may deliver a beat only if ready was high three cycles earlier
            if (hist[3] && src_q.size() > 0 && (mode != 1 || lfsr[1])) begin
                {in_data, in_sop, in_eop, in_empty} = src_q.pop_front();
                in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
            hdr_ready = (mode == 1) ? (lfsr[2] | lfsr[5]) : 1'b1;
            pl_ready  = (mode == 0) ? 1'b1 : (mode == 1) ? (lfsr[3] | lfsr[7]) : ((cyc % 64) >= 40);
            if (hdr_valid && hdr_ready) begin
                if (exp_h.size() == 0) chk(0, "R11 unexpected header", {4'h0, hdr_four, hdr_data}, '0);
                else begin
                    logic [128:0] e;
                    e = exp_h.pop_front();
                    chk({hdr_four, hdr_data} == e, "R2", {4'h0, hdr_four, hdr_data}, {4'h0, e});
                end
            end
            if (pl_valid && pl_ready) begin
                if (exp_p.size() == 0) chk(0, "R7 unexpected payload", {pl_data, pl_dwen, pl_last}, '0);
                else begin
                    logic [132:0] e;
                    string tg;
                    e  = exp_p.pop_front();
                    tg = tag_p.pop_front();
                    chk({pl_data, pl_dwen, pl_last} == e, tg, {pl_data, pl_dwen, pl_last}, e);
                end
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        #1;
        chk(hdr_valid == 1'b0, "R1 hdr_valid", 133'(hdr_valid), 133'(0));
        chk(pl_valid == 1'b0, "R1 pl_valid", 133'(pl_valid), 133'(0));
        chk(in_ready == 1'b1, "R1 in_ready", 133'(in_ready), 133'(1));
        @(negedge clk);
        rst_n = 1'b1;
        for (int m = 0; m < 3; m++) begin
            mode = m;
            // sweep: header size, payload presence, address bit 2, length
            for (int f = 0; f < 2; f++)
                for (int a = 0; a < 2; a++) begin
                    make_pkt(f[0], 1'b0, a[0], 5);         // R7 header-only, length ignored
                    for (int l = 1; l <= 9; l++) make_pkt(f[0], 1'b1, a[0], l);
                end
            while ((src_q.size() > 0 || exp_h.size() > 0 || exp_p.size() > 0) && cyc < LIMIT)
                @(negedge clk);
            repeat (20) @(negedge clk);
            if (cyc >= LIMIT) begin
                chk(0, "watchdog", 133'(cyc), 133'(LIMIT));
                break;
            end
            // R9 and R11: every packet fully delivered in back-to-back flow
            chk(src_q.size() == 0 && exp_h.size() == 0 && exp_p.size() == 0, "R9 drain",
                133'(exp_h.size() + exp_p.size()), 133'(0));
            if (m == 2) chk(saw_low, "R8 ready dropped under stall", 133'(saw_low), 133'(1));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule